// File: doc/BRIEF.md
# PLL Control Register Block with Relock Model

This block is the software-facing side of one phase-locked loop in a clock generation unit. It holds a single 32-bit control word. The word sets the power state, a bypass path and three divider fields. The block turns those fields into the ratio between the PLL output and its reference clock, given as a numerator and a denominator, and drives that ratio onto output ports for the rest of the clock tree.

The block also carries a behavioural model of how the loop settles. Every reprogramming of the control word drops the lock indication at the next clock edge. Lock then returns after a fixed number of register-clock cycles (`LOCK_CYCLES`), as long as the loop is not powered down. A written setting whose ratio falls outside an allowed window raises an error flag. That flag stays set until a later control write lands inside the window.

Access goes through a plain 32-bit read/write strobe port with word addresses. Reads are registered and return data one cycle after the strobe. Two further word slots exist for frequency measurement and monitoring. Both read as zero and discard writes.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the control word reads 0x00000000, lock and error are both low, and the decoded ratio is 2/1 (numerator 2, denominator 1).
- R2: A write to byte offset 0x0 stores bits 15:0 and the 4-bit band field at bits 23:20. All other bits read back as zero. A read strobe returns data on `bus_rdata` after the next clock edge, and the value is held until the next read.
- R3: In normal mode (bits 1:0 both zero), the feedback field (bits 15:9, value F), the input-divider field (bits 8:4, value I) and the output-divider field (bits 3:2, value O) give numerator 2*(F+1) and denominator (I+1)*2^O.
- R4: When bit 1 (bypass) is set, the ratio is 1/1, whatever the other fields hold, and `bypass_o` is high.
- R5: When bit 0 (power-down) is set and bit 1 is clear, the ratio is 0/1 (stopped), and `pdown_o` is high.
- R6: A read at byte offset 0x4 returns lock in bit 0 and error in bit 1. All higher bits are zero.
- R7: Any control write drives lock low after the same edge that stores the word. Lock rises again exactly `LOCK_CYCLES` edges after that write. A second write during the wait restarts the count.
- R8: While bit 0 (power-down) of the stored word is set, lock stays low however long the wait.
- R9: A control write in normal mode sets error when numerator < RATIO_MIN*denominator or numerator > RATIO_MAX*denominator, with both bounds inclusive-allowed. Any control write whose ratio is allowed, or that sets bypass or power-down, clears error. Error changes on the same edge as the control word.
- R10: Reads at byte offsets 0x8 and 0xC return zero. Writes there change neither the control word nor lock.
- R11: After reset is released, lock rises exactly `LOCK_CYCLES` edges later, as for a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lock_o | output | 1 | Modelled lock indication |
| err_o | output | 1 | Ratio-window error |
| pdown_o | output | 1 | Stored power-down bit |
| bypass_o | output | 1 | Stored bypass bit |
| ratio_num_o | output | 9 | Output/reference ratio numerator |
| ratio_den_o | output | 9 | Output/reference ratio denominator |

## Verification
The bench walks settings that cover each edge of the error window:
- a ratio of exactly 32 and exactly 1, which are allowed;
- a ratio of 34 and 0.5, which are rejected.

An off-by-one comparison in the window would flag the wrong one of these settings. It checks that bypass overrides garbage divider fields, and that bypass wins over power-down. A decoder that gave bypass lower priority would report a stopped clock. Lock timing is sampled one cycle before and at the expected rise, both after a single write and after a write that lands mid-count. A timer that did not restart, or that counted one extra edge, would show lock at the wrong sample. A write to the measurement slot while locked must not disturb lock or the stored word, which catches address decode that aliases onto the control slot.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
   // control word field layout (fixed: software encodes these positions)
   localparam int PD_BIT    = 0;
   localparam int BYP_BIT   = 1;
   localparam int OD_LSB    = 2;
   localparam int OD_W      = 2;
   localparam int ID_LSB    = 4;
   localparam int ID_W      = 5;
   localparam int FB_LSB    = 9;
   localparam int FB_W      = 7;
   localparam int CORE_W    = 16;
   localparam int BAND_LSB  = 20;

   // ratio widths derived from the field widths
   localparam int NUM_W     = FB_W + 2;
   localparam int DEN_W     = ID_W + 1 + (2 ** OD_W) - 1;

   // word slots (byte offset / 4)
   typedef enum logic [1:0] {
      SLOT_CTL  = 2'd0,
      SLOT_STS  = 2'd1,
      SLOT_MEAS = 2'd2,
      SLOT_MON  = 2'd3
   } slot_e;
endpackage

// File: rtl/pll_ratio_decode.sv
module pll_ratio_decode
   import pll_ctl_pkg::*;
(
   input  logic [CORE_W-1:0] ctl_i,
   output logic [NUM_W-1:0]  num_o,
   output logic [DEN_W-1:0]  den_o,
   output logic              normal_o
);
   logic [FB_W-1:0] fb;
   logic [ID_W-1:0] id;
   logic [OD_W-1:0] od;
   logic [NUM_W-1:0] num_lin;
   logic [DEN_W-1:0] den_lin;

   assign fb = ctl_i[FB_LSB +: FB_W];
   assign id = ctl_i[ID_LSB +: ID_W];
   assign od = ctl_i[OD_LSB +: OD_W];

   // feedback multiplies by 2*(F+1); input divides by I+1, output by 2^O
   assign num_lin = (NUM_W'(fb) + NUM_W'(1)) << 1;
   assign den_lin = (DEN_W'(id) + DEN_W'(1)) << od;

   always_comb begin
      normal_o = 1'b0;
      if (ctl_i[BYP_BIT]) begin
         num_o = NUM_W'(1);
         den_o = DEN_W'(1);
      end else if (ctl_i[PD_BIT]) begin
         num_o = '0;
         den_o = DEN_W'(1);
      end else begin
         num_o    = num_lin;
         den_o    = den_lin;
         normal_o = 1'b1;
      end
   end
endmodule

// File: rtl/pll_ratio_window.sv
module pll_ratio_window
   import pll_ctl_pkg::*;
#(
   parameter int RATIO_MIN = 1,
   parameter int RATIO_MAX = 32
) (
   input  logic             en_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             bad_o
);
   localparam int PROD_W = 32;
   logic [PROD_W-1:0] num_x, lo_lim, hi_lim;

   assign num_x  = PROD_W'(num_i);
   assign lo_lim = PROD_W'(RATIO_MIN) * PROD_W'(den_i);
   assign hi_lim = PROD_W'(RATIO_MAX) * PROD_W'(den_i);
   assign bad_o  = en_i && ((num_x < lo_lim) || (num_x > hi_lim));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int LOCK_CYCLES = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic hold_i,
   output logic lock_o
);
   localparam int CNT_W = $clog2(LOCK_CYCLES) + 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= LOAD;
         busy_q <= 1'b1;
         lock_o <= 1'b0;
      end else if (restart_i) begin
         cnt_q  <= LOAD;
         busy_q <= 1'b1;
         lock_o <= 1'b0;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
            lock_o <= ~hold_i;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else if (hold_i) begin
         lock_o <= 1'b0;
      end
   end

   p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> !lock_o);
   p_lock_needs_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(busy_q));
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
   import pll_ctl_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int LOCK_CYCLES = 10000,
   parameter int RATIO_MIN   = 1,
   parameter int RATIO_MAX   = 32,
   parameter bit HAS_BAND    = 1'b1,
   parameter int BAND_W      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                lock_o,
   output logic                err_o,
   output logic                pdown_o,
   output logic                bypass_o,
   output logic [NUM_W-1:0]    ratio_num_o,
   output logic [DEN_W-1:0]    ratio_den_o
);
   localparam int SLOT_W = ADDR_W - 2;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 4)              begin : g_chk_addr  $error("ADDR_W must be at least 4"); end
      if (LOCK_CYCLES < 1)         begin : g_chk_lock  $error("LOCK_CYCLES must be at least 1"); end
      if (RATIO_MIN > RATIO_MAX)   begin : g_chk_win   $error("RATIO_MIN above RATIO_MAX"); end
      if (BAND_LSB + BAND_W > 32)  begin : g_chk_band  $error("band field exceeds word"); end
   endgenerate

   // address decode over the full word address
   logic [SLOT_W-1:0] slot;
   logic hit_ctl, hit_sts;
   logic ctl_wr;
   assign slot    = bus_addr[ADDR_W-1:2];
   assign hit_ctl = (slot == SLOT_W'(SLOT_CTL));
   assign hit_sts = (slot == SLOT_W'(SLOT_STS));
   assign ctl_wr  = bus_wr && hit_ctl;

   logic unused_lsb;
   assign unused_lsb = ^bus_addr[1:0];

   // core control fields
   logic [CORE_W-1:0] core_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      core_q <= '0;
      else if (ctl_wr) core_q <= bus_wdata[CORE_W-1:0];
   end

   // optional band field
   logic [31:0] band_rd;
   generate
      if (HAS_BAND) begin : g_band
         logic [BAND_W-1:0] band_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      band_q <= '0;
            else if (ctl_wr) band_q <= bus_wdata[BAND_LSB +: BAND_W];
         end
         assign band_rd = 32'(band_q) << BAND_LSB;
      end else begin : g_noband
         assign band_rd = '0;
      end
   endgenerate

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata[31:CORE_W];

   // live decode of the stored word
   logic live_normal;
   pll_ratio_decode i_dec_live (
      .ctl_i    (core_q),
      .num_o    (ratio_num_o),
      .den_o    (ratio_den_o),
      .normal_o (live_normal)
   );

   // decode of the word being written, for the error check
   logic [NUM_W-1:0] wr_num;
   logic [DEN_W-1:0] wr_den;
   logic             wr_normal, wr_bad;
   pll_ratio_decode i_dec_wr (
      .ctl_i    (bus_wdata[CORE_W-1:0]),
      .num_o    (wr_num),
      .den_o    (wr_den),
      .normal_o (wr_normal)
   );

   pll_ratio_window #(
      .RATIO_MIN (RATIO_MIN),
      .RATIO_MAX (RATIO_MAX)
   ) i_win (
      .en_i  (wr_normal),
      .num_i (wr_num),
      .den_i (wr_den),
      .bad_o (wr_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_o <= 1'b0;
      else if (ctl_wr) err_o <= wr_bad;
   end

   assign pdown_o  = core_q[PD_BIT];
   assign bypass_o = core_q[BYP_BIT];

   pll_lock_timer #(
      .LOCK_CYCLES (LOCK_CYCLES)
   ) i_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (ctl_wr),
      .hold_i    (core_q[PD_BIT]),
      .lock_o    (lock_o)
   );

   // registered read port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         if (hit_ctl)      bus_rdata <= 32'(core_q) | band_rd;
         else if (hit_sts) bus_rdata <= {30'd0, err_o, lock_o};
         else              bus_rdata <= '0;
      end
   end

   // assertions
   p_bypass_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_o |-> (ratio_num_o == NUM_W'(1) && ratio_den_o == DEN_W'(1)));
   p_pd_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pdown_o && !bypass_o) |-> (ratio_num_o == '0));
   p_den_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_den_o != '0);
   p_pd_nolock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pdown_o |-> !lock_o);
   p_err_clear_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[BYP_BIT]) |=> !err_o);
   p_side_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit_ctl && !hit_sts) |=> (bus_rdata == '0));
   p_side_wr_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit_ctl) |=> $stable(core_q));
endmodule

// File: tb/test_pll_ctl_regs.sv
module test_pll_ctl_regs;
   localparam int CLK_PERIOD = 10;
   localparam int LOCKN      = 16;
   localparam int NV         = 13;

   // written word, readback, num, den, err, pd, bypass
   localparam logic [31:0] V_WR [NV] = '{32'h0A14, 32'h2E04, 32'h5E10, 32'h01FC, 32'h01FE,
      32'h5E11, 32'h0003, 32'hFF7FAA14, 32'hFE00, 32'h1E00, 32'h0010, 32'h0014, 32'h2000};
   localparam logic [31:0] V_RB [NV] = '{32'h0A14, 32'h2E04, 32'h5E10, 32'h01FC, 32'h01FE,
      32'h5E11, 32'h0003, 32'h0070AA14, 32'hFE00, 32'h1E00, 32'h0010, 32'h0014, 32'h2000};
   localparam int V_NUM [NV] = '{12, 48, 96, 2, 1, 0, 1, 172, 256, 32, 2, 2, 34};
   localparam int V_DEN [NV] = '{4, 2, 2, 256, 1, 1, 1, 4, 1, 1, 2, 4, 1};
   localparam bit V_ERR [NV] = '{0, 0, 1, 1, 0, 0, 0, 1, 1, 0, 0, 1, 1};
   localparam bit V_PD  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0};
   localparam bit V_BYP [NV] = '{0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        lock_o, err_o, pdown_o, bypass_o;
   logic [8:0]  ratio_num_o, ratio_den_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_ctl_regs #(.LOCK_CYCLES(LOCKN)) i_pll_ctl_regs (
      .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
      .lock_o, .err_o, .pdown_o, .bypass_o, .ratio_num_o, .ratio_den_o);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: lock returns LOCKN edges after reset release
      repeat (LOCKN - 1) @(negedge clk);
      check("R11 lock before", 32'(lock_o), 0);
      @(negedge clk);
      check("R11 lock rise", 32'(lock_o), 1);
      // R1: reset state
      check("R1 err", 32'(err_o), 0);
      check("R1 num", 32'(ratio_num_o), 2);
      check("R1 den", 32'(ratio_den_o), 1);
      rd(4'h0, d);
      check("R1 ctl read", d, 0);

      // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         wr(4'h0, V_WR[i]);
         check("R7 lock drop", 32'(lock_o), 0);
         check("R3 num", 32'(ratio_num_o), 32'(V_NUM[i]));
         check("R3 den", 32'(ratio_den_o), 32'(V_DEN[i]));
         check("R9 err", 32'(err_o), 32'(V_ERR[i]));
         check("R5 pdown", 32'(pdown_o), 32'(V_PD[i]));
         check("R4 bypass", 32'(bypass_o), 32'(V_BYP[i]));
         repeat (LOCKN - 1) @(negedge clk);
         check("R7 lock wait", 32'(lock_o), 0);
         @(negedge clk);
         check("R8 lock after wait", 32'(lock_o), 32'(!V_PD[i]));
         rd(4'h0, d);
         check("R2 readback", d, V_RB[i]);
         rd(4'h4, d);
         check("R6 status", d, {30'd0, V_ERR[i], !V_PD[i]});
      end

      // R7: write during count restarts the wait
      wr(4'h0, 32'h0A14);
      repeat (5) @(negedge clk);
      wr(4'h0, 32'h2E04);
      repeat (LOCKN - 1) @(negedge clk);
      check("R7 restart before", 32'(lock_o), 0);
      @(negedge clk);
      check("R7 restart rise", 32'(lock_o), 1);

      // R10: side slots read zero, writes ignored
      wr(4'h8, 32'hFFFF_FFFF);
      wr(4'hC, 32'hFFFF_FFFF);
      check("R10 lock kept", 32'(lock_o), 1);
      check("R10 num kept", 32'(ratio_num_o), 48);
      rd(4'h0, d);
      check("R10 ctl kept", d, 32'h2E04);
      rd(4'h8, d);
      check("R10 meas zero", d, 0);
      rd(4'hC, d);
      check("R10 mon zero", d, 0);

      // R8: power-down holds lock low over a long wait
      wr(4'h0, 32'h5E11);
      repeat (3 * LOCKN) @(negedge clk);
      check("R8 long pd", 32'(lock_o), 0);
      // R9: valid write clears error left by a bad one
      wr(4'h0, 32'hFE00);
      check("R9 err set", 32'(err_o), 1);
      wr(4'h0, 32'h0A14);
      check("R9 err cleared", 32'(err_o), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule